// File: doc/BRIEF.md
# Fixed-Priority Credit-Gated Output Arbiter

This block serves one output port of a wormhole-switched on-chip router in which every priority level owns its own virtual channel. In each clock cycle it examines the head flit offered by every input virtual channel that is routed to this port. It forwards at most one of those flits to the downstream router. The choice is strict fixed priority at flit granularity, so a more urgent channel can take the port back between any two flits of a less urgent one.

The block holds one credit counter for each downstream virtual channel. Each counter starts at the downstream buffer depth. A channel whose counter is zero is passed over, and the port goes to the next lower priority that has both a flit and a credit. Credits returned from downstream refill the counters.

The grant is produced combinationally from the requests and the registered counters, so an input buffer can pop its head flit in the same cycle. With the default variant, the forwarded flit and its priority tag appear on a register stage one cycle after the grant.

Top module: `prio_out_arb`

## Requirements
- R1: While reset is held, and at the first cycle after it, every credit counter equals CRED_DEPTH, `out_vld_o` is 0, and `gnt_o` is 0 when no request is present.
- R2: Priority index 0 is the most urgent. `gnt_o` has at most one bit set, and that bit is the lowest index whose `req_i` bit is 1 and whose credit counter is nonzero.
- R3: `gnt_o` is all zero whenever no channel both requests and holds a credit. This covers the case where channels request but all are out of credits.
- R4: Each grant on a priority lowers that priority's counter by one. After CRED_DEPTH grants with no returns, that priority receives no further grant.
- R5: A requesting priority with a zero counter is skipped, and the port goes to the next lower-priority requester that has credit.
- R6: A `cred_ret_i` pulse raises that priority's counter by one at the clock edge. The restored credit can first be used for a grant in the following cycle, not in the cycle of the return.
- R7: A credit return and a grant on the same priority in the same cycle leave that counter unchanged.
- R8: With OUT_REG=1, the cycle after a grant on priority p shows `out_vld_o`=1, `out_flit_o` equal to the flit offered on `flit_i[p*FLIT_W +: FLIT_W]` in the grant cycle, and `out_prio_o`=p. The cycle after no grant shows `out_vld_o`=0.
- R9: Preemption happens per flit. When a more urgent channel with credit starts requesting while a less urgent one is streaming, the more urgent one is granted in that same cycle. The less urgent one resumes once the more urgent one stops.
- R10: Once every outstanding credit has been returned, a priority can again be granted exactly CRED_DEPTH times in a row before it blocks. Returns never raise a counter above CRED_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_PRIO | Head flit present, one bit per priority channel |
| flit_i | input | NUM_PRIO*FLIT_W | Head flits, priority p in bits p*FLIT_W +: FLIT_W |
| cred_ret_i | input | NUM_PRIO | One credit returned from downstream, per priority |
| gnt_o | output | NUM_PRIO | One-hot pop strobe to the winning channel |
| out_vld_o | output | 1 | Forwarded flit valid |
| out_flit_o | output | FLIT_W | Forwarded flit |
| out_prio_o | output | $clog2(NUM_PRIO) | Priority tag of the forwarded flit |

## Verification
The assertions assume that the downstream router returns a credit only for a slot it actually freed. In practice, this means a return on a priority whose counter is already at CRED_DEPTH must be paired with a grant on that same priority in the same cycle. The bench keeps its own count of outstanding credits for every priority and issues returns only where that count shows a slot in use. It also holds each flit input stable from the negedge at which it is driven through the next rising edge.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

   // Width of a counter that must hold values 0..depth inclusive.
   function automatic int unsigned cnt_width(input int unsigned depth);
      return (depth < 1) ? 1 : $clog2(depth + 1);
   endfunction

   // Width of an index into n entries (never below one bit).
   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Selects how the fixed-priority picker is built.
   typedef enum int unsigned {
      PICK_LINEAR = 0,
      PICK_TWOS   = 1
   } pick_style_e;

endpackage

// File: rtl/prio_arb_credit_ctr.sv
module prio_arb_credit_ctr
   import prio_arb_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned CW   = cnt_width(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          send_i,
   input  logic          ret_i,
   output logic [CW-1:0] cnt_o,
   output logic          avail_o
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= FULL;
      end else begin
         unique case ({ret_i, send_i})
            2'b10: if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
            2'b01: if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign cnt_o   = cnt_q;
   assign avail_o = (cnt_q != '0);

endmodule

// File: rtl/prio_arb_picker.sv
module prio_arb_picker
   import prio_arb_pkg::*;
#(
   parameter int unsigned N     = 4,
   parameter int unsigned STYLE = PICK_LINEAR,
   localparam int unsigned IW   = idx_width(N)
) (
   input  logic [N-1:0]  elig_i,
   output logic [N-1:0]  gnt_o,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);

   logic [N-1:0] gnt;

   generate
      if (STYLE == PICK_TWOS) begin : g_twos
         // Isolate the lowest set bit (index 0 is most urgent).
         assign gnt = elig_i & (~elig_i + 1'b1);
      end else begin : g_linear
         always_comb begin
            gnt = '0;
            for (int p = N - 1; p >= 0; p--) begin
               if (elig_i[p]) gnt = N'(1) << p;
            end
         end
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int p = 0; p < N; p++) begin
         if (gnt[p]) idx_o = idx_o | IW'(p);
      end
   end

   assign gnt_o = gnt;
   assign any_o = |elig_i;

endmodule

// File: rtl/prio_arb_out_stage.sv
module prio_arb_out_stage
   import prio_arb_pkg::*;
#(
   parameter int unsigned N       = 4,
   parameter int unsigned FW      = 32,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned IW     = idx_width(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          any_i,
   input  logic [IW-1:0] idx_i,
   input  logic [N*FW-1:0] flits_i,
   output logic          vld_o,
   output logic [FW-1:0] flit_o,
   output logic [IW-1:0] prio_o
);

   logic [FW-1:0] sel_flit;

   always_comb begin
      sel_flit = '0;
      for (int p = 0; p < N; p++) begin
         if (idx_i == IW'(p)) sel_flit = flits_i[p*FW +: FW];
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         logic          vld_q;
         logic [FW-1:0] flit_q;
         logic [IW-1:0] prio_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               flit_q <= '0;
               prio_q <= '0;
            end else begin
               vld_q <= any_i;
               if (any_i) begin
                  flit_q <= sel_flit;
                  prio_q <= idx_i;
               end
            end
         end

         assign vld_o  = vld_q;
         assign flit_o = flit_q;
         assign prio_o = prio_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign vld_o  = any_i;
         assign flit_o = sel_flit;
         assign prio_o = idx_i;
      end
   endgenerate

endmodule

// File: rtl/prio_out_arb.sv
module prio_out_arb
   import prio_arb_pkg::*;
#(
   parameter int unsigned NUM_PRIO   = 4,
   parameter int unsigned FLIT_W     = 32,
   parameter int unsigned CRED_DEPTH = 4,
   parameter int unsigned PICK_STYLE = PICK_LINEAR,
   parameter bit          OUT_REG    = 1'b1,
   localparam int unsigned PW        = idx_width(NUM_PRIO),
   localparam int unsigned CW        = cnt_width(CRED_DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PRIO-1:0]        req_i,
   input  logic [NUM_PRIO*FLIT_W-1:0] flit_i,
   input  logic [NUM_PRIO-1:0]        cred_ret_i,
   output logic [NUM_PRIO-1:0]        gnt_o,
   output logic                       out_vld_o,
   output logic [FLIT_W-1:0]          out_flit_o,
   output logic [PW-1:0]              out_prio_o
);

   // Elaboration-time parameter checks.
   generate
      if (NUM_PRIO < 2) begin : g_bad_prio
         $error("prio_out_arb: NUM_PRIO must be at least 2");
      end
      if (FLIT_W < 1) begin : g_bad_width
         $error("prio_out_arb: FLIT_W must be at least 1");
      end
      if (CRED_DEPTH < 1) begin : g_bad_depth
         $error("prio_out_arb: CRED_DEPTH must be at least 1");
      end
      if (PICK_STYLE > PICK_TWOS) begin : g_bad_style
         $error("prio_out_arb: unknown PICK_STYLE");
      end
   endgenerate

   logic [NUM_PRIO-1:0]    has_cred;
   logic [NUM_PRIO-1:0]    elig;
   logic [NUM_PRIO-1:0]    gnt;
   logic [PW-1:0]          win_idx;
   logic                   win_any;
   logic [NUM_PRIO*CW-1:0] cred_cnt;

   generate
      for (genvar p = 0; p < NUM_PRIO; p++) begin : g_cred
         prio_arb_credit_ctr #(
            .DEPTH (CRED_DEPTH)
         ) ctr_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .send_i  (gnt[p]),
            .ret_i   (cred_ret_i[p]),
            .cnt_o   (cred_cnt[p*CW +: CW]),
            .avail_o (has_cred[p])
         );
      end
   endgenerate

   assign elig = req_i & has_cred;

   prio_arb_picker #(
      .N     (NUM_PRIO),
      .STYLE (PICK_STYLE)
   ) pick_i (
      .elig_i (elig),
      .gnt_o  (gnt),
      .idx_o  (win_idx),
      .any_o  (win_any)
   );

   prio_arb_out_stage #(
      .N       (NUM_PRIO),
      .FW      (FLIT_W),
      .OUT_REG (OUT_REG)
   ) out_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_i   (win_any),
      .idx_i   (win_idx),
      .flits_i (flit_i),
      .vld_o   (out_vld_o),
      .flit_o  (out_flit_o),
      .prio_o  (out_prio_o)
   );

   assign gnt_o = gnt;

endmodule

// File: rtl/prio_out_arb_chk.sv
module prio_out_arb_chk
   import prio_arb_pkg::*;
#(
   parameter int unsigned NUM_PRIO   = 4,
   parameter int unsigned CRED_DEPTH = 4,
   parameter bit          OUT_REG    = 1'b1,
   localparam int unsigned PW        = idx_width(NUM_PRIO),
   localparam int unsigned CW        = cnt_width(CRED_DEPTH)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_PRIO-1:0]    req_i,
   input logic [NUM_PRIO-1:0]    cred_ret_i,
   input logic [NUM_PRIO-1:0]    gnt_o,
   input logic                   out_vld_o,
   input logic [PW-1:0]          out_prio_o,
   input logic [NUM_PRIO*CW-1:0] cnt_i
);

   localparam logic [CW-1:0] FULL = CW'(CRED_DEPTH);

   logic [NUM_PRIO-1:0] nz;
   always_comb begin
      for (int p = 0; p < NUM_PRIO; p++) nz[p] = (cnt_i[p*CW +: CW] != '0);
   end

   // R2: never more than one grant
   p_onehot_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));

   // R3: a requester with credit means the port is not left idle
   p_work_conserve_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(req_i & nz)) |-> (|gnt_o));

   generate
      for (genvar p = 0; p < NUM_PRIO; p++) begin : g_p
         // R2: grant only to a requesting channel
         p_gnt_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[p] |-> req_i[p]);

         // R4: grant only with a credit in hand
         p_gnt_credit_r4: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[p] |-> nz[p]);

         // R4: a send without return consumes one credit
         p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_o[p] && !cred_ret_i[p]) |=>
               (cnt_i[p*CW +: CW] == $past(cnt_i[p*CW +: CW]) - 1'b1));

         // R6: a return without send adds one credit
         p_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cred_ret_i[p] && !gnt_o[p]) |=>
               (cnt_i[p*CW +: CW] == $past(cnt_i[p*CW +: CW]) + 1'b1));

         // R7: send and return together leave the count alone
         p_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cred_ret_i[p] && gnt_o[p]) |=> $stable(cnt_i[p*CW +: CW]));

         // R10: a return may not push a counter past its depth
         p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (cred_ret_i[p] && !gnt_o[p]) |-> (cnt_i[p*CW +: CW] < FULL));

         if (OUT_REG) begin : g_tag
            // R8: forwarded flit carries the priority granted a cycle earlier
            p_out_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
               gnt_o[p] |=> (out_vld_o && out_prio_o == PW'(p)));
         end
      end

      if (OUT_REG) begin : g_idle
         // R8: no grant, no output the next cycle
         p_out_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(|gnt_o) |=> !out_vld_o);
      end
   endgenerate

endmodule

bind prio_out_arb prio_out_arb_chk #(
   .NUM_PRIO   (NUM_PRIO),
   .CRED_DEPTH (CRED_DEPTH),
   .OUT_REG    (OUT_REG)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_i      (req_i),
   .cred_ret_i (cred_ret_i),
   .gnt_o      (gnt_o),
   .out_vld_o  (out_vld_o),
   .out_prio_o (out_prio_o),
   .cnt_i      (cred_cnt)
);

// File: tb/prio_out_arb_tb_top.sv
module prio_out_arb_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 4;
   localparam int FW         = 16;
   localparam int DEPTH      = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NP-1:0]   req_i = '0;
   logic [NP*FW-1:0] flit_i = '0;
   logic [NP-1:0]   cred_ret_i = '0;
   logic [NP-1:0]   gnt_o;
   logic            out_vld_o;
   logic [FW-1:0]   out_flit_o;
   logic [1:0]      out_prio_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_out_arb #(
      .NUM_PRIO   (NP),
      .FLIT_W     (FW),
      .CRED_DEPTH (DEPTH)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .flit_i     (flit_i),
      .cred_ret_i (cred_ret_i),
      .gnt_o      (gnt_o),
      .out_vld_o  (out_vld_o),
      .out_flit_o (out_flit_o),
      .out_prio_o (out_prio_o)
   );

   int checks = 0;
   int errors = 0;
   int stamp  = 0;
   int exp_cnt [NP];
   logic          prev_vld = 1'b0;
   logic [FW-1:0] prev_flit = '0;
   int            prev_prio = 0;
   bit            done = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // One cycle: drive at negedge, check grant and the previous cycle's output.
   task automatic cyc(input logic [NP-1:0] r, input logic [NP-1:0] rt,
                      input string tag);
      logic [NP-1:0] eg;
      int win;
      @(negedge clk);
      stamp++;
      req_i      = r;
      cred_ret_i = rt;
      for (int p = 0; p < NP; p++) flit_i[p*FW +: FW] = FW'(p*4096 + stamp);
      #1;
      chk(out_vld_o == prev_vld, "R8", "out_vld", int'(out_vld_o), int'(prev_vld));
      if (prev_vld) begin
         chk(out_flit_o == prev_flit, "R8", "out_flit", int'(out_flit_o), int'(prev_flit));
         chk(int'(out_prio_o) == prev_prio, "R8", "out_prio", int'(out_prio_o), prev_prio);
      end
      win = -1;
      for (int p = NP - 1; p >= 0; p--) if (r[p] && exp_cnt[p] > 0) win = p;
      eg = (win >= 0) ? NP'(1) << win : '0;
      chk(gnt_o == eg, tag, "gnt", int'(gnt_o), int'(eg));
      prev_vld = (win >= 0);
      if (win >= 0) begin
         prev_flit = flit_i[win*FW +: FW];
         prev_prio = win;
      end
      for (int p = 0; p < NP; p++)
         exp_cnt[p] = exp_cnt[p] + int'(rt[p]) - int'(eg[p]);
   endtask

   task automatic restore(input string tag);
      logic [NP-1:0] rt;
      for (int k = 0; k < DEPTH; k++) begin
         rt = '0;
         for (int p = 0; p < NP; p++) if (exp_cnt[p] < DEPTH) rt[p] = 1'b1;
         cyc('0, rt, tag);
      end
   endtask

   task automatic t_reset();
      #1;
      chk(out_vld_o == 1'b0, "R1", "out_vld in reset", int'(out_vld_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc('0, '0, "R1");
      cyc(4'b1111, '0, "R1");
      restore("R1");
   endtask

   task automatic t_priority();
      cyc(4'b1010, '0, "R2");
      cyc(4'b1100, '0, "R2");
      cyc(4'b1000, '0, "R2");
      cyc(4'b0110, '0, "R2");
      restore("R2");
   endtask

   task automatic t_idle_exhaust();
      cyc('0, '0, "R3");
      for (int k = 0; k < DEPTH + 1; k++) cyc(4'b0010, '0, "R4");
      chk(gnt_o == '0, "R4", "gnt after depth sends", int'(gnt_o), 0);
      for (int k = 0; k < DEPTH; k++) cyc(4'b1000, '0, "R4");
      cyc(4'b1010, '0, "R3");
      restore("R4");
   endtask

   task automatic t_skip();
      for (int k = 0; k < DEPTH; k++) cyc(4'b0001, '0, "R5");
      cyc(4'b0011, '0, "R5");
      cyc(4'b0101, '0, "R5");
      chk(gnt_o == 4'b0100, "R5", "skip to p2", int'(gnt_o), 4);
      cyc(4'b0001, 4'b0001, "R6");
      chk(gnt_o == '0, "R6", "credit not usable same cycle", int'(gnt_o), 0);
      cyc(4'b0001, '0, "R6");
      chk(gnt_o == 4'b0001, "R6", "credit usable next cycle", int'(gnt_o), 1);
      restore("R6");
   endtask

   task automatic t_same_cycle();
      for (int k = 0; k < 2 * DEPTH; k++) cyc(4'b0100, 4'b0100, "R7");
      for (int k = 0; k < DEPTH; k++) cyc(4'b0100, '0, "R7");
      chk(gnt_o == 4'b0100, "R7", "last credit still present", int'(gnt_o), 4);
      cyc(4'b0100, '0, "R7");
      restore("R7");
   endtask

   task automatic t_preempt();
      cyc(4'b1000, '0, "R9");
      cyc(4'b1010, '0, "R9");
      chk(gnt_o == 4'b0010, "R9", "preempt mid-stream", int'(gnt_o), 2);
      cyc(4'b1010, '0, "R9");
      cyc(4'b1000, '0, "R9");
      chk(gnt_o == 4'b1000, "R9", "resume", int'(gnt_o), 8);
      restore("R9");
   endtask

   task automatic t_refill();
      int n = 0;
      for (int k = 0; k < DEPTH + 2; k++) begin
         cyc(4'b0001, '0, "R10");
         if (gnt_o[0]) n++;
      end
      chk(n == DEPTH, "R10", "grants after refill", n, DEPTH);
      restore("R10");
      cyc('0, '0, "R10");
   endtask

   initial begin
      for (int p = 0; p < NP; p++) exp_cnt[p] = DEPTH;
      repeat (3) @(negedge clk);
      t_reset();
      t_priority();
      t_idle_exhaust();
      t_skip();
      t_same_cycle();
      t_preempt();
      t_refill();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule